// File: doc/BRIEF.md
# Burst-Correcting FEC Block Encoder

This block turns a stream of 64b/66b blocks into forward-error-corrected codewords for a backplane link. It collects 32 incoming blocks and reduces each 2-bit sync header to a single bit, so every block adds 65 bits. The 32 blocks together form a 2080-bit payload. A 32-bit parity field follows the payload. It is the remainder of a shortened cyclic code that can correct a single burst of errors. The 2112-bit codeword is then XORed with a pseudo-noise sequence that starts over with every codeword. The result is a stream of 16-bit words toward the physical medium attachment, and a marker flags the first word of each codeword.

Both sides are valid/ready streams. A block is taken on a cycle where `in_valid` and `in_ready` are both high. A word leaves on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the word and its marker stay unchanged until they are taken. `in_ready` depends combinationally on `out_ready`, because a word leaving the internal bit buffer frees room for the next block in the same cycle. The encoder stops taking input while it sends the two parity words. With the input kept full and `out_ready` held high, the output has one idle cycle per codeword.

Top module: `bfec_encoder`

## Requirements
- R1: A block is taken only when `in_valid` and `in_ready` are both high. Exactly 32 blocks are taken per codeword. `in_ready` stays low from the 32nd block of a codeword until the codeword's last word has left, including the whole time the two parity words are on the output.
- R2: The payload is sent in arrival order, block by block. Within a block the derived header bit goes first, followed by `in_data[0]` through `in_data[63]`. Bit 0 of each output word is its earliest bit. The payload fills words 0 to 129 of the codeword.
- R3: The derived header bit is `in_hdr[1] & ~in_hdr[0]`: header 2'b01 gives 0 and header 2'b10 gives 1.
- R4: Words 130 and 131 carry the remainder of payload·x^32 modulo g(x)=x^32+x^23+x^21+x^11+x^2+1, with the x^31 coefficient first. Before scrambling, the whole 2112-bit codeword, first bit as the highest degree, is a multiple of g(x).
- R5: Every codeword bit is XORed with a pseudo-noise bit. A 58-bit state s produces it: the PN bit is s[57]^s[38], and s then shifts up by one with that bit entering at s[0]. At the start of every codeword, s is reloaded with 58'h2AAAAAAAAAAAAAA (bit i set exactly when i is odd). Two codewords with the same content therefore give the same output words.
- R6: A codeword is 132 output words. `out_sop` is high together with `out_valid` on word 0 of each codeword, and on no other word.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high, with `out_data` and `out_sop` unchanged.
- R8: Reset empties the encoder and restarts codeword framing, parity and PN. Right after reset, `out_valid` and `out_sop` are 0 and `in_ready` is 1.
- R9: With `in_valid` and `out_ready` held high, back-to-back codewords start exactly 133 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Encoder can take a block this cycle |
| in_hdr | input | 2 | Sync header of the 66-bit block |
| in_data | input | 64 | Data bits of the 66-bit block |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 16 | Scrambled codeword word, bit 0 earliest |
| out_sop | output | 1 | Marks word 0 of a codeword |

## Verification
Several properties are checked on every cycle. A stalled word and its marker must hold steady. The marker must appear only on word 0 of a 132-word frame, counted from the handshakes alone. The input must never be ready while parity words are out, or after 32 blocks of a frame have been taken. Other behaviour can only be shown by the bench's scenarios, which descramble and reassemble whole codewords. These cover the payload bit order, the header compression, the parity being a true multiple of the generator, the restart of the PN sequence at each codeword and after a mid-frame reset, and the 133-cycle codeword spacing under full load.

// File: rtl/bfec_pkg.sv
package bfec_pkg;
  // Low 32 coefficients of x^32+x^23+x^21+x^11+x^2+1
  localparam logic [31:0] BFEC_POLY    = 32'h00A0_0805;
  // Scrambler seed: odd stages set, top stage (57) holds 1
  localparam logic [57:0] BFEC_PN_SEED = 58'h2AA_AAAA_AAAA_AAAA;
  localparam int          BFEC_PN_W    = 58;
  localparam int          BFEC_PN_TAP  = 39;
endpackage

// File: rtl/bfec_pack.sv
module bfec_pack #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 16,
  parameter int BLOCKS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              hdr_bit,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pop,
  input  logic              frame_end,
  output logic              word_avail,
  output logic [WORD_W-1:0] word
);
  localparam int BLK_W = DATA_W + 1;
  localparam int BUF_W = WORD_W - 1 + BLK_W;
  localparam int CNT_W = $clog2(BUF_W + 1);
  localparam int BC_W  = $clog2(BLOCKS + 1);
  localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] BLK_C  = CNT_W'(BLK_W);

  logic [BUF_W-1:0] buf_q, buf_left, buf_next;
  logic [CNT_W-1:0] cnt_q, cnt_left, cnt_next;
  logic [BC_W-1:0]  blk_q;
  logic             take;

  always_comb begin
    cnt_left = pop ? (cnt_q - WORD_C) : cnt_q;
    buf_left = pop ? (buf_q >> WORD_W) : buf_q;
    in_ready = (blk_q < BC_W'(BLOCKS)) && (cnt_left < WORD_C);
    take     = in_valid & in_ready;
    buf_next = buf_left;
    cnt_next = cnt_left;
    if (take) begin
      buf_next = buf_left | (BUF_W'({in_data, hdr_bit}) << cnt_left);
      cnt_next = cnt_left + BLK_C;
    end
  end

  assign word_avail = (cnt_q >= WORD_C);
  assign word       = buf_q[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
      blk_q <= '0;
    end else begin
      buf_q <= buf_next;
      cnt_q <= cnt_next;
      if (frame_end)  blk_q <= '0;
      else if (take)  blk_q <= blk_q + BC_W'(1);
    end
  end
endmodule

// File: rtl/bfec_parity.sv
module bfec_parity #(
  parameter int              WORD_W = 16,
  parameter int              PAR_W  = 32,
  parameter logic [PAR_W-1:0] POLY  = bfec_pkg::BFEC_POLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              absorb,
  input  logic [WORD_W-1:0] word_in,
  input  logic              emit,
  output logic [WORD_W-1:0] par_word
);
  logic [PAR_W-1:0] par_q, par_upd;

  // Fold WORD_W message bits into the remainder, bit 0 first
  always_comb begin
    logic [PAR_W-1:0] r;
    logic             fb;
    r = par_q;
    for (int i = 0; i < WORD_W; i++) begin
      fb = word_in[i] ^ r[PAR_W-1];
      r  = {r[PAR_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    par_upd = r;
  end

  always_comb begin
    for (int i = 0; i < WORD_W; i++) par_word[i] = par_q[PAR_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) par_q <= '0;
    else if (absorb)   par_q <= par_upd;
    else if (emit)     par_q <= par_q << WORD_W;
  end
endmodule

// File: rtl/bfec_pn.sv
module bfec_pn #(
  parameter int              WORD_W = 16,
  parameter int              PN_W   = bfec_pkg::BFEC_PN_W,
  parameter int              PN_TAP = bfec_pkg::BFEC_PN_TAP,
  parameter logic [PN_W-1:0] SEED   = bfec_pkg::BFEC_PN_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  output logic [WORD_W-1:0] mask
);
  logic [PN_W-1:0] st_q, st_next;

  always_comb begin
    logic [PN_W-1:0] s;
    logic            b;
    s = st_q;
    for (int i = 0; i < WORD_W; i++) begin
      b       = s[PN_W-1] ^ s[PN_TAP-1];
      mask[i] = b;
      s       = {s[PN_W-2:0], b};
    end
    st_next = s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) st_q <= SEED;
    else if (adv)          st_q <= st_next;
  end
endmodule

// File: rtl/bfec_encoder.sv
module bfec_encoder #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 16,
  parameter int BLOCKS = 32,
  parameter int PAR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_hdr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop
);
  localparam int PAY_WORDS   = BLOCKS * (DATA_W + 1) / WORD_W;
  localparam int FRAME_WORDS = PAY_WORDS + PAR_W / WORD_W;
  localparam int WC_W        = $clog2(FRAME_WORDS);

  logic [WC_W-1:0]   wc_q;
  logic              in_par, fire, pop, emit, last, word_avail, hdr_bit;
  logic [WORD_W-1:0] pay_word, par_word, mask;

  assign hdr_bit   = in_hdr[1] & ~in_hdr[0];
  assign in_par    = (wc_q >= WC_W'(PAY_WORDS));
  assign out_valid = in_par | word_avail;
  assign fire      = out_valid & out_ready;
  assign pop       = fire & ~in_par;
  assign emit      = fire & in_par;
  assign last      = fire && (wc_q == WC_W'(FRAME_WORDS - 1));
  assign out_sop   = out_valid && (wc_q == '0);
  assign out_data  = (in_par ? par_word : pay_word) ^ mask;

  bfec_pack #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BLOCKS(BLOCKS)) u_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hdr_bit(hdr_bit),
    .in_data(in_data), .in_ready(in_ready), .pop(pop), .frame_end(last),
    .word_avail(word_avail), .word(pay_word)
  );

  bfec_parity #(.WORD_W(WORD_W), .PAR_W(PAR_W)) u_par (
    .clk(clk), .rst_n(rst_n), .clr(last), .absorb(pop), .word_in(pay_word),
    .emit(emit), .par_word(par_word)
  );

  bfec_pn #(.WORD_W(WORD_W)) u_pn (
    .clk(clk), .rst_n(rst_n), .restart(last), .adv(fire), .mask(mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    wc_q <= '0;
    else if (fire) wc_q <= last ? '0 : wc_q + WC_W'(1);
  end
endmodule

// File: rtl/bfec_encoder_chk.sv
module bfec_encoder_chk #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 16,
  parameter int BLOCKS = 32,
  parameter int PAR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_sop
);
  localparam int PAY_WORDS   = BLOCKS * (DATA_W + 1) / WORD_W;
  localparam int FRAME_WORDS = PAY_WORDS + PAR_W / WORD_W;

  int  wc, acc;
  logic ofire;
  assign ofire = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wc  <= 0;
      acc <= 0;
    end else begin
      if (ofire) wc <= (wc == FRAME_WORDS - 1) ? 0 : wc + 1;
      if (ofire && wc == FRAME_WORDS - 1) acc <= 0;
      else if (in_valid && in_ready)     acc <= acc + 1;
    end
  end

  AST_SOP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid); // R6
  AST_SOP_AT_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
    ofire |-> (out_sop == (wc == 0))); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop))); // R7
  AST_NO_INPUT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (wc >= PAY_WORDS) |-> !in_ready); // R1
  AST_BLOCK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (acc < BLOCKS)); // R1
endmodule

bind bfec_encoder bfec_encoder_chk #(
  .DATA_W(DATA_W), .WORD_W(WORD_W), .BLOCKS(BLOCKS), .PAR_W(PAR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop)
);

// File: tb/bfec_encoder_tb.sv
`timescale 1ns/1ps
module bfec_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_hdr = 2'b01;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_sop;

  always #2.5 clk = ~clk;

  bfec_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop)
  );

  typedef struct packed {
    logic [1:0]  hm;      // 0: hdr 01, 1: hdr 10, 2: mixed by seed
    logic [1:0]  dm;      // 0: zeros, 1: ones, 2: hashed
    logic        gap;     // random input gaps
    logic        stall;   // random output stalls
    logic [31:0] seed;
    logic [7:0]  exp_gap; // expected cycles from previous start, 0 = skip
  } scen_t;

  localparam int NSC = 9;
  localparam scen_t SCEN [NSC] = '{
    '{2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 8'd0},
    '{2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 8'd133},
    '{2'd1, 2'd1, 1'b0, 1'b0, 32'h0000_0000, 8'd133},
    '{2'd2, 2'd2, 1'b0, 1'b0, 32'h1234_5678, 8'd133},
    '{2'd2, 2'd2, 1'b1, 1'b0, 32'hCAFE_F00D, 8'd0},
    '{2'd2, 2'd2, 1'b0, 1'b1, 32'h0BAD_BEEF, 8'd0},
    '{2'd2, 2'd2, 1'b1, 1'b1, 32'h7777_1111, 8'd0},
    '{2'd1, 2'd2, 1'b0, 1'b0, 32'h5A5A_A5A5, 8'd0},
    '{2'd0, 2'd2, 1'b0, 1'b0, 32'h0F0F_3C3C, 8'd133}
  };

  int total = 0, bad = 0, cyc = 0, prev_sop = -1;
  logic        done = 1'b0;
  logic [15:0] rnd = 16'hACE1;
  logic [1:0]  hq [32];
  logic [63:0] dq [32];
  logic [15:0] wq [132];
  logic [15:0] ref0 [132];
  logic        cw [2112];

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic gen(input scen_t s);
    for (int b = 0; b < 32; b++) begin
      logic [31:0] x;
      case (s.hm)
        2'd0:    hq[b] = 2'b01;
        2'd1:    hq[b] = 2'b10;
        default: hq[b] = ((s.seed >> b) & 32'd1) != 0 ? 2'b10 : 2'b01;
      endcase
      x = s.seed * 32'h9E37_79B1 + 32'(b) * 32'h85EB_CA6B;
      case (s.dm)
        2'd0:    dq[b] = '0;
        2'd1:    dq[b] = '1;
        default: dq[b] = {x, x ^ 32'hDEAD_BEEF ^ (32'(b) << 8)};
      endcase
    end
  endtask

  task automatic run_frame(input scen_t s, input int fidx);
    int   nb = 0, nw = 0, t = 0, sop_cyc = -1;
    int   sop_err = 0, par_err = 0, hold_err = 0;
    logic pend = 1'b0, offer = 1'b0;
    logic [15:0] pend_data = '0;
    logic pend_sop = 1'b0;
    gen(s);
    while (nw < 132 && t < 5000) begin
      @(negedge clk);
      if (!(offer && !in_ready_taken_hold(offer)))
        offer = (nb < 32) && !(s.gap && rnd[0]);
      in_valid  = offer;
      in_hdr    = hq[nb < 32 ? nb : 0];
      in_data   = dq[nb < 32 ? nb : 0];
      out_ready = !(s.stall && rnd[3]);
      #1;
      if (pend) begin
        if (!out_valid || out_data != pend_data || out_sop != pend_sop) hold_err++;
      end
      pend = 1'b0;
      if (in_valid && in_ready) begin
        nb++;
        offer = 1'b0;
      end
      if (out_valid) begin
        if (out_ready) begin
          wq[nw] = out_data;
          if (out_sop != (nw == 0)) sop_err++;
          if (nw == 0) sop_cyc = cyc;
          if (nw >= 130 && in_ready) par_err++;
          nw++;
        end else begin
          pend = 1'b1; pend_data = out_data; pend_sop = out_sop;
        end
      end
      rnd = {rnd[14:0], rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10]};
      cyc++; t++;
    end
    in_valid = 1'b0;
    chk(t < 5000, "R6", "frame completes within watchdog", t, 5000);
    chk(sop_err == 0, "R6", "out_sop only on word 0", sop_err, 0);
    chk(nb == 32 && par_err == 0, "R1", "32 blocks taken, no input during parity",
        {nb, par_err}, {32'd32, 32'd0});
    if (s.stall)
      chk(hold_err == 0, "R7", "stalled word held", hold_err, 0);
    begin
      logic [57:0] st = 58'h2AA_AAAA_AAAA_AAAA;
      logic [31:0] r  = '0;
      int hd_bad = 0, da_bad = 0, first = -1;
      for (int w = 0; w < 132; w++)
        for (int i = 0; i < 16; i++) begin
          logic m;
          m  = st[57] ^ st[38];
          st = {st[56:0], m};
          cw[w*16+i] = wq[w][i] ^ m;
        end
      for (int b = 0; b < 32; b++) begin
        if (cw[b*65] != (hq[b] == 2'b10)) hd_bad++;
        for (int k = 0; k < 64; k++)
          if (cw[b*65+1+k] != dq[b][k]) begin
            da_bad++;
            if (first < 0) first = b*65+1+k;
          end
      end
      chk(hd_bad == 0, "R3", "compressed header bits", hd_bad, 0);
      chk(da_bad == 0, "R2", "payload bit order after descramble (R5 mask)", first, -1);
      for (int j = 0; j < 2112; j++) begin
        logic top;
        top = r[31];
        r   = {r[30:0], cw[j]};
        if (top) r = r ^ 32'h00A0_0805;
      end
      chk(r == 0, "R4", "codeword remainder modulo g", r, 0);
    end
    if (fidx == 0) for (int w = 0; w < 132; w++) ref0[w] = wq[w];
    if (fidx == 1 || fidx < 0) begin
      int diff = 0;
      for (int w = 0; w < 132; w++) if (wq[w] != ref0[w]) diff++;
      chk(diff == 0, "R5", "PN restarts: identical codeword repeats", diff, 0);
    end
    if (s.exp_gap != 0)
      chk(sop_cyc - prev_sop == int'(s.exp_gap), "R9", "codeword start spacing",
          sop_cyc - prev_sop, s.exp_gap);
    prev_sop = sop_cyc;
  endtask

  // Keeps an offered but not yet taken block on the bus
  function automatic logic in_ready_taken_hold(input logic o);
    return !o;
  endfunction

  task automatic check_reset_state(input string what);
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R8", {what, " out_valid"}, out_valid, 0);
    chk(out_sop == 1'b0,   "R8", {what, " out_sop"},   out_sop, 0);
    chk(in_ready == 1'b1,  "R8", {what, " in_ready"},  in_ready, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state("after power-up reset");
    for (int k = 0; k < NSC; k++) run_frame(SCEN[k], k);
    // Directed: reset in the middle of a codeword, then repeat scenario 0
    gen(SCEN[3]);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      in_valid = 1'b1; in_hdr = hq[c % 32]; in_data = dq[c % 32]; out_ready = 1'b1;
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0; cyc++;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc += 2;
    check_reset_state("after mid-frame reset");
    run_frame(SCEN[0], -1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL R6 watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule